// File: doc/BRIEF.md
# Phase-Frequency Detector with Polarity Swap

This block compares two divided clocks, a reference-side clock and a feedback-side clock, and turns the time between their rising edges into pump pulses. A rising edge on the reference side opens a source (pump-up) pulse. A rising edge on the feedback side opens a sink (pump-down) pulse. When both have opened, both clear together, so the width of the surviving pulse equals the lead, counted in clock cycles. Both divided clocks are level signals produced in the same clock domain as `clk`, and the block detects their edges by sampling.

A single polarity control swaps the source and sink actions for loops whose oscillator gain has the opposite sign. The same control chooses which divided clock is shown on the monitor output. A primary pump command is always driven. A secondary pump command, used to speed up acquisition, is driven only while the gate control is high. When the gate is low, its drive flag is low and its command is idle, which stands in for a floating output. A separate source/sink pair is brought out for an external charge pump.

A lock flag rises once the detector has gone through four consecutive comparison periods in which no pulse lasted longer than a programmable number of cycles. Both controls are asynchronous and pass through two-flop synchronizers. Every interface here is a plain level signal: there is no data stream and no valid/ready handshake.

Top module: `pfd_swap_top`

## Requirements
- R1: With the polarity control high, a reference rising edge that leads the feedback rising edge by d cycles gives a source pulse of exactly d cycles on `pri_cmd_o` (encoding 2'b01 = source, 2'b10 = sink, 2'b00 = idle). The pulse starts one cycle after the edge is sampled.
- R2: With the polarity control high, a feedback rising edge that leads the reference rising edge by d cycles gives a sink pulse (2'b10) of exactly d cycles.
- R3: Reference and feedback edges sampled in the same cycle produce no pulse.
- R4: With the polarity control low, the source and sink actions are swapped on every pump output: reference lead gives 2'b10 and feedback lead gives 2'b01.
- R5: `mon_o` carries `fr_i` while the synchronized polarity control is high, and `fp_i` while it is low.
- R6: `pri_cmd_o` is driven whatever the level of the gate control.
- R7: `sec_drive_o` follows the synchronized gate control. While it is high, `sec_cmd_o` equals `pri_cmd_o`. While it is low, `sec_cmd_o` is 2'b00.
- R8: `phr_o` is high exactly while the effective source action is active, and `php_o` is high exactly while the effective sink action is active.
- R9: `lock_o` is high once four consecutive reference rising edges have been seen with no pump pulse wider than `lock_win_i` cycles. It goes low the cycle after any pulse exceeds that width.
- R10: `pol_sel_i` and `sec_gate_i` take effect on the outputs after two clock edges. Both synchronizers reset to 1.
- R11: During reset, both pump commands are idle, `lock_o` is low, and `sec_drive_o` is high.
- R12: The internal source and sink pulses are never both active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fr_i | input | 1 | Reference-divided clock, synchronous to clk |
| fp_i | input | 1 | Feedback-divided clock, synchronous to clk |
| pol_sel_i | input | 1 | Polarity and monitor select, asynchronous (1 = normal, monitor shows fr_i) |
| sec_gate_i | input | 1 | Secondary pump gate, asynchronous |
| lock_win_i | input | PW_W | Widest pulse, in cycles, still counted as in lock |
| pri_cmd_o | output | 2 | Primary pump command {sink, source} |
| sec_cmd_o | output | 2 | Secondary pump command {sink, source} |
| sec_drive_o | output | 1 | Secondary pump is driven (low = floating) |
| phr_o | output | 1 | External pump source request |
| php_o | output | 1 | External pump sink request |
| mon_o | output | 1 | Monitor copy of the selected divided clock |
| lock_o | output | 1 | Lock indication |

## Verification
The bench sweeps the feedback edge from four cycles ahead of the reference edge to six cycles behind it, at every combination of polarity and gate level. It counts cycles of source and sink on every pump output and compares them with the expected lead. Zero offset separates the simultaneous-edge case from a one-cycle lead. The two polarity settings separate a correct swap from an unswapped detector, and the two gate levels separate a gated secondary pump from an always-driven one. The lock flag is checked with offsets on both sides of the pulse-width window and with windows of 0 and 3. A short run of three clean periods that follows a failing one separates the four-period rule from a shorter count. The reset values of the synchronizers are checked on the monitor output just after reset.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int CMD_W   = 2;
  localparam int SRC_BIT = 0;
  localparam int SNK_BIT = 1;

  function automatic logic [CMD_W-1:0] pump_cmd(input logic src, input logic snk);
    logic [CMD_W-1:0] c;
    c = '0;
    c[SRC_BIT] = src;
    c[SNK_BIT] = snk;
    return c;
  endfunction
endpackage

// File: rtl/pfd_sync2.sv
module pfd_sync2 #(
  parameter int               WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      sync_o <= RST_VAL;
    end else begin
      stage1 <= async_i;
      sync_o <= stage1;
    end
  end
endmodule

// File: rtl/pfd_detect.sv
module pfd_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic fr_i,
  input  logic fp_i,
  output logic up_o,
  output logic dn_o,
  output logic fr_rise_o
);
  logic fr_d, fp_d;
  logic fr_rise, fp_rise;
  logic up_set, dn_set, both_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_d <= 1'b0;
      fp_d <= 1'b0;
    end else begin
      fr_d <= fr_i;
      fp_d <= fp_i;
    end
  end

  always_comb begin
    fr_rise  = fr_i & ~fr_d;
    fp_rise  = fp_i & ~fp_d;
    up_set   = up_o | fr_rise;
    dn_set   = dn_o | fp_rise;
    both_set = up_set & dn_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_o <= 1'b0;
      dn_o <= 1'b0;
    end else begin
      up_o <= up_set & ~both_set;
      dn_o <= dn_set & ~both_set;
    end
  end

  assign fr_rise_o = fr_rise;

  AST_NO_BOTH_PUMPS: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_o && dn_o)); // R12
  AST_UP_ON_REF: assert property (@(posedge clk) disable iff (!rst_n)
    fr_rise && !fp_rise && !dn_o |=> up_o); // R1
  AST_UP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    up_o && !fp_rise |=> up_o); // R1
  AST_DN_ON_FB: assert property (@(posedge clk) disable iff (!rst_n)
    fp_rise && !fr_rise && !up_o |=> dn_o); // R2
  AST_SAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    fr_rise && fp_rise && !up_o && !dn_o |=> !up_o && !dn_o); // R3
endmodule

// File: rtl/pfd_lock.sv
module pfd_lock #(
  parameter int PW_W         = 8,
  parameter int LOCK_PERIODS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            up_i,
  input  logic            dn_i,
  input  logic            fr_rise_i,
  input  logic [PW_W-1:0] win_i,
  output logic            lock_o
);
  localparam int GW = $clog2(LOCK_PERIODS + 1);
  localparam logic [GW-1:0] GOOD_MAX = GW'(LOCK_PERIODS);

  logic [PW_W-1:0] width_cnt;
  logic [GW-1:0]   good_cnt;
  logic            active, excess;

  always_comb begin
    active = up_i | dn_i;
    excess = active && (width_cnt >= win_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_cnt <= '0;
    end else if (active) begin
      if (width_cnt != '1) width_cnt <= width_cnt + 1'b1;
    end else begin
      width_cnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_cnt <= '0;
    end else if (excess) begin
      good_cnt <= '0;
    end else if (fr_rise_i && good_cnt != GOOD_MAX) begin
      good_cnt <= good_cnt + 1'b1;
    end
  end

  assign lock_o = (good_cnt == GOOD_MAX);

  AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    excess |=> !lock_o); // R9
  AST_LOCK_RISE_ON_REF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(fr_rise_i)); // R9
endmodule

// File: rtl/pfd_swap_top.sv
module pfd_swap_top #(
  parameter int PW_W         = 8,
  parameter int LOCK_PERIODS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fr_i,
  input  logic            fp_i,
  input  logic            pol_sel_i,
  input  logic            sec_gate_i,
  input  logic [PW_W-1:0] lock_win_i,
  output logic [1:0]      pri_cmd_o,
  output logic [1:0]      sec_cmd_o,
  output logic            sec_drive_o,
  output logic            phr_o,
  output logic            php_o,
  output logic            mon_o,
  output logic            lock_o
);
  import pfd_pkg::*;

  logic [1:0] ctl_sync;
  logic       pol_s, gate_s;
  logic       up, dn, fr_rise;
  logic       src, snk;
  logic [CMD_W-1:0] cmd;

  pfd_sync2 #(.WIDTH(2), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({pol_sel_i, sec_gate_i}),
    .sync_o(ctl_sync)
  );

  assign pol_s  = ctl_sync[1];
  assign gate_s = ctl_sync[0];

  pfd_detect u_det (
    .clk(clk), .rst_n(rst_n), .fr_i(fr_i), .fp_i(fp_i),
    .up_o(up), .dn_o(dn), .fr_rise_o(fr_rise)
  );

  pfd_lock #(.PW_W(PW_W), .LOCK_PERIODS(LOCK_PERIODS)) u_lock (
    .clk(clk), .rst_n(rst_n), .up_i(up), .dn_i(dn),
    .fr_rise_i(fr_rise), .win_i(lock_win_i), .lock_o(lock_o)
  );

  always_comb begin
    src = pol_s ? up : dn;
    snk = pol_s ? dn : up;
    cmd = pump_cmd(src, snk);
  end

  assign pri_cmd_o   = cmd;
  assign phr_o       = src;
  assign php_o       = snk;
  assign sec_drive_o = gate_s;
  assign sec_cmd_o   = gate_s ? cmd : '0;
  assign mon_o       = pol_s ? fr_i : fp_i;

  AST_SEC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    sec_drive_o |-> sec_cmd_o == pri_cmd_o); // R7
  AST_SEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_drive_o |-> sec_cmd_o == 2'b00); // R7
  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    pri_cmd_o != 2'b11); // R12
  AST_EXT_PAIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(phr_o && php_o)); // R8
endmodule

// File: tb/pfd_swap_top_test.sv
`timescale 1ns/1ps
module pfd_swap_top_test;
  localparam int PW_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fr_i = 1'b0, fp_i = 1'b0, pol_sel_i = 1'b0, sec_gate_i = 1'b0;
  logic [PW_W-1:0] lock_win_i = 8'd3;
  logic [1:0] pri_cmd_o, sec_cmd_o;
  logic sec_drive_o, phr_o, php_o, mon_o, lock_o;

  int total = 0;
  int failed = 0;

  pfd_swap_top #(.PW_W(PW_W), .LOCK_PERIODS(4)) uut (
    .clk(clk), .rst_n(rst_n), .fr_i(fr_i), .fp_i(fp_i),
    .pol_sel_i(pol_sel_i), .sec_gate_i(sec_gate_i), .lock_win_i(lock_win_i),
    .pri_cmd_o(pri_cmd_o), .sec_cmd_o(sec_cmd_o), .sec_drive_o(sec_drive_o),
    .phr_o(phr_o), .php_o(php_o), .mon_o(mon_o), .lock_o(lock_o)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - failed, total);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check("watchdog expired", 1, 0);
    summary();
    $finish;
  end

  // one configuration: offset d (fp edge minus fr edge), counts over the last period
  task automatic run_cfg(input int d, input bit fc, input bit le, input int win,
                         input int nper, input int exp_lock);
    int p_src = 0, p_snk = 0, s_src = 0, s_snk = 0, x_r = 0, x_p = 0;
    int mon_bad = 0, drv_bad = 0;
    int lead, lag, e_src, e_snk;
    pol_sel_i = fc; sec_gate_i = le; lock_win_i = PW_W'(win);
    fr_i = 1'b0; fp_i = 1'b0;
    repeat (8) begin @(posedge clk); #1; end
    for (int p = 0; p < nper; p++) begin
      for (int c = 0; c < 16; c++) begin
        @(posedge clk); #1;
        fr_i = (c >= 4 && c < 12);
        fp_i = (c >= 4 + d && c < 12 + d);
        @(negedge clk);
        if (p == nper - 1) begin
          p_src += int'(pri_cmd_o == 2'b01);
          p_snk += int'(pri_cmd_o == 2'b10);
          s_src += int'(sec_cmd_o == 2'b01);
          s_snk += int'(sec_cmd_o == 2'b10);
          x_r   += int'(phr_o);
          x_p   += int'(php_o);
          mon_bad += int'(mon_o != (fc ? fr_i : fp_i));
          drv_bad += int'(sec_drive_o != le);
        end
      end
    end
    lead = (d > 0) ? d : 0;
    lag  = (d < 0) ? -d : 0;
    e_src = fc ? lead : lag;
    e_snk = fc ? lag : lead;
    check($sformatf("R1 R2 R3 R4 R6 primary source d=%0d fc=%0d le=%0d", d, fc, le), p_src, e_src);
    check($sformatf("R1 R2 R3 R4 R6 primary sink d=%0d fc=%0d le=%0d", d, fc, le), p_snk, e_snk);
    check($sformatf("R7 secondary source d=%0d fc=%0d le=%0d", d, fc, le), s_src, le ? e_src : 0);
    check($sformatf("R7 secondary sink d=%0d fc=%0d le=%0d", d, fc, le), s_snk, le ? e_snk : 0);
    check($sformatf("R7 drive flag mismatches le=%0d", le), drv_bad, 0);
    check($sformatf("R8 phr cycles d=%0d fc=%0d", d, fc), x_r, e_src);
    check($sformatf("R8 php cycles d=%0d fc=%0d", d, fc), x_p, e_snk);
    check($sformatf("R5 monitor mismatches fc=%0d", fc), mon_bad, 0);
    if (exp_lock >= 0)
      check($sformatf("R9 lock d=%0d win=%0d periods=%0d", d, win, nper), int'(lock_o), exp_lock);
  endtask

  initial begin
    // reset: fr low, fp high, polarity input low
    fr_i = 1'b0; fp_i = 1'b1; pol_sel_i = 1'b0; sec_gate_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 reset primary idle", int'(pri_cmd_o), 0);
    check("R11 reset secondary idle", int'(sec_cmd_o), 0);
    check("R11 reset lock low", int'(lock_o), 0);
    check("R11 R10 reset drive flag high", int'(sec_drive_o), 1);
    check("R10 reset polarity shows fr", int'(mon_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 polarity still high after one edge", int'(mon_o), 0);
    check("R10 gate still high after one edge", int'(sec_drive_o), 1);
    @(negedge clk);
    check("R10 polarity low after two edges", int'(mon_o), 1);
    check("R10 gate low after two edges", int'(sec_drive_o), 0);

    for (int d = -4; d <= 6; d++)
      for (int f = 0; f < 2; f++)
        for (int g = 0; g < 2; g++)
          run_cfg(d, f[0], g[0], 3, 6, ((d <= 3) && (d >= -3)) ? 1 : 0);

    run_cfg(0, 1'b1, 1'b1, 0, 6, 1);
    run_cfg(1, 1'b1, 1'b1, 0, 6, 0);
    run_cfg(-1, 1'b0, 1'b1, 0, 6, 0);
    // four consecutive periods needed
    run_cfg(6, 1'b1, 1'b1, 3, 6, 0);
    run_cfg(0, 1'b1, 1'b1, 3, 3, 0);
    run_cfg(0, 1'b1, 1'b1, 3, 1, 1);
    run_cfg(4, 1'b1, 1'b0, 3, 1, 0);

    summary();
    $finish;
  end
endmodule